// File: doc/BRIEF.md
# Video Memory DMA Engine

This block carries out the three block-transfer operations of a video display controller: moving words from the system bus into one of the three video memories, filling video RAM with a repeated byte, and copying bytes from one video RAM location to another. The command decoder and register file sit outside the block. They give the engine its enable bit, the mode, the length, the source, the step size, the current target and the shared address. The engine answers with one memory write per clock. When it finishes, it returns one write-back cycle that carries the new address and source values.

A bus transfer or a copy begins when the decoder presents a command that has its transfer bit set. A fill is different: the command only prepares it, and the fill begins on the next data-port write. Every operation first latches its parameters. It then runs for the programmed number of units, with a length of zero meaning 65536. After the last unit it spends one cycle handing the final values back to the register file.

Top module: `vmem_dma_engine`

## Requirements
- R1: A command trigger (`cmd_req`) or a fill trigger is accepted only while `dma_en` is high and the engine is idle, meaning neither running nor in its write-back cycle. Any other trigger leaves the outputs unchanged.
- R2: The length is `len_reg` in units, and a value of 0 means 65536. The first unit appears in the cycle after acceptance, and one unit is issued in every following cycle until the length is used up.
- R3: `mode_reg` selects the operation. Values 0 and 1 select a bus transfer and 3 selects a copy, each started by `cmd_req`. Value 2 selects a fill, and `cmd_req` alone never starts it.
- R4: A bus transfer reads word i from byte address `{src_reg[21:16], (src_reg[15:0]+i) mod 2^16, 0}` and writes it on the word port.
  - The target code picks the memory: 0 is VRAM, 1 is CRAM, 2 is VSRAM and 3 is none, in which case nothing is written.
  - For VRAM the word index is destination bits 15:1, and the data is byte-swapped when destination bit 0 is 1.
  - For CRAM and VSRAM the index is destination bits 6:1.
- R5: A fill starts on a data-port write while `cmd_dma_bit` is 1 and the mode is 2. It writes bits 15:8 of that data word to successive VRAM byte addresses. When the target is not VRAM it writes nothing, but it still runs for the full length.
- R6: A copy reads the byte at `(src_reg[15:0]+i) mod 2^16` on the byte read port and writes it to the current destination on the byte write port.
- R7: The destination starts at `addr_in` and advances by `inc_reg` after every unit, wrapping modulo 2^16.
- R8: In the cycle after the last unit, `wb_en` is high for exactly one cycle.
  - `wb_addr` equals `(addr_in + N*inc_reg) mod 2^16`, where N is the unit count.
  - `wb_src` equals `(src_reg[15:0] + N) mod 2^16`.
  - The pulse tells the register file to clear the length.
- R9: `active` is high in every unit cycle. `busy_stat` is high in the unit cycles of fills and copies, and low during bus transfers. Both outputs are low after reset and in the write-back cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Transfer enable bit from the mode register |
| cmd_req | input | 1 | Command with transfer bit set has just been decoded |
| cmd_dma_bit | input | 1 | Transfer bit of the command currently held |
| mode_reg | input | 2 | Operation select |
| len_reg | input | 16 | Unit count, 0 meaning 65536 |
| src_reg | input | 22 | Source: bits 21:16 bank, bits 15:0 running part |
| inc_reg | input | 8 | Destination step |
| tgt_sel | input | 2 | Current target memory code |
| addr_in | input | 16 | Shared destination address |
| dp_wr | input | 1 | Data-port write strobe |
| dp_data | input | 16 | Data-port write word |
| ext_addr | output | 23 | Bus byte address of the source word |
| ext_rdata | input | 16 | Source word, valid in the same cycle |
| ww_en | output | 1 | Word write strobe |
| ww_tgt | output | 2 | Word write target code |
| ww_idx | output | 15 | Word index within the target |
| ww_data | output | 16 | Word write data |
| bw_en | output | 1 | VRAM byte write strobe |
| bw_addr | output | 16 | VRAM byte write address |
| bw_data | output | 8 | VRAM byte write data |
| br_addr | output | 16 | VRAM byte read address for copy |
| br_data | input | 8 | VRAM byte read data, valid in the same cycle |
| wb_en | output | 1 | Register write-back strobe |
| wb_addr | output | 16 | Final destination for the shared address |
| wb_src | output | 16 | New low 16 source bits |
| active | output | 1 | An operation is issuing units |
| busy_stat | output | 1 | Status busy flag for fill and copy |

## Verification
The assertions assume three things about the environment:
- Both source read ports answer combinationally in the same cycle.
- The register inputs hold valid values in the cycle a trigger is sampled.
- The two triggers never arrive in the same cycle.

The stimulus changes inputs only at the falling edge, and it uses read ports that are pure functions of the address. It raises one trigger at a time, except when it deliberately fires both triggers, with altered register values, during a running operation to show they are ignored. Each operation is compared cycle by cycle against a model that enumerates the expected units, including address wrap, byte swapping on odd destinations, palette index wrap and the 65536-unit case.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    typedef enum logic [1:0] {
        K_BUS  = 2'd0,
        K_FILL = 2'd1,
        K_COPY = 2'd2
    } xfer_kind_e;

    typedef enum logic [1:0] {
        T_VRAM  = 2'd0,
        T_CRAM  = 2'd1,
        T_VSRAM = 2'd2,
        T_NONE  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_WB   = 2'd2
    } phase_e;

    localparam logic [1:0] MODE_FILL = 2'd2;
    localparam logic [1:0] MODE_COPY = 2'd3;

    typedef struct packed {
        xfer_kind_e kind;
        tgt_e       tgt;
        logic [7:0] fill;
    } job_t;

    function automatic xfer_kind_e kind_from_mode(input logic [1:0] m);
        if (m == MODE_COPY) return K_COPY;
        if (m == MODE_FILL) return K_FILL;
        return K_BUS;
    endfunction

    function automatic logic [15:0] swap_bytes(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/vdma_seq.sv
module vdma_seq
    import vdma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             idle,
    output logic             run,
    output logic             wb
);
    localparam int CNT_W = LEN_W + 1;

    phase_e           phase;
    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= S_IDLE;
            left  <= '0;
        end else begin
            case (phase)
                S_IDLE: if (start) begin
                    phase <= S_RUN;
                    left  <= (len == '0) ? (CNT_W'(1) << LEN_W) : {1'b0, len};
                end
                S_RUN: begin
                    left <= left - 1'b1;
                    if (left == CNT_W'(1)) phase <= S_WB;
                end
                default: phase <= S_IDLE;
            endcase
        end
    end

    assign idle = (phase == S_IDLE);
    assign run  = (phase == S_RUN);
    assign wb   = (phase == S_WB);

    assert_start_runs_R2: assert property (@(posedge clk) disable iff (rst)
        (idle && start) |=> run);
    assert_count_live_R2: assert property (@(posedge clk) disable iff (rst)
        run |-> (left != '0));
    assert_wb_single_R8: assert property (@(posedge clk) disable iff (rst)
        wb |=> idle);

endmodule

// File: rtl/vdma_ptr.sv
module vdma_ptr #(
    parameter int ADDR_W = 16,
    parameter int INC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [INC_W-1:0]  inc,
    output logic [ADDR_W-1:0] dst,
    output logic [ADDR_W-1:0] src
);
    logic [INC_W-1:0] inc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dst   <= '0;
            src   <= '0;
            inc_q <= '0;
        end else if (load) begin
            dst   <= dst_init;
            src   <= src_init;
            inc_q <= inc;
        end else if (step) begin
            dst <= dst + ADDR_W'(inc_q);
            src <= src + ADDR_W'(1);
        end
    end

    assert_dst_step_R7: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (dst == $past(dst) + ADDR_W'($past(inc_q))));
    assert_src_step_R6: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (src == $past(src) + ADDR_W'(1)));

endmodule

// File: rtl/vdma_port.sv
module vdma_port
    import vdma_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int SRC_HI_W = 6,
    parameter int PAL_W    = 6
) (
    input  logic                       run,
    input  job_t                       job,
    input  logic [ADDR_W-1:0]          dst,
    input  logic [ADDR_W-1:0]          src,
    input  logic [SRC_HI_W-1:0]        src_hi,
    input  logic [15:0]                ext_rdata,
    input  logic [7:0]                 br_data,
    output logic [SRC_HI_W+ADDR_W:0]   ext_addr,
    output logic                       ww_en,
    output logic [1:0]                 ww_tgt,
    output logic [ADDR_W-2:0]          ww_idx,
    output logic [15:0]                ww_data,
    output logic                       bw_en,
    output logic [ADDR_W-1:0]          bw_addr,
    output logic [7:0]                 bw_data,
    output logic [ADDR_W-1:0]          br_addr
);
    logic to_vram;

    always_comb begin
        to_vram  = (job.tgt == T_VRAM);
        ext_addr = {src_hi, src, 1'b0};
        br_addr  = src;
        ww_en    = run && (job.kind == K_BUS) && (job.tgt != T_NONE);
        ww_tgt   = job.tgt;
        ww_idx   = to_vram ? dst[ADDR_W-1:1] : (ADDR_W-1)'(dst[PAL_W:1]);
        ww_data  = (to_vram && dst[0]) ? swap_bytes(ext_rdata) : ext_rdata;
        bw_en    = run && ((job.kind == K_COPY) || (job.kind == K_FILL && to_vram));
        bw_addr  = dst;
        bw_data  = (job.kind == K_COPY) ? br_data : job.fill;
    end

endmodule

// File: rtl/vmem_dma_engine.sv
module vmem_dma_engine
    import vdma_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 16,
    parameter int SRC_HI_W = 6,
    parameter int INC_W    = 8,
    parameter int PAL_W    = 6,
    localparam int SRC_W   = SRC_HI_W + ADDR_W,
    localparam int EXT_W   = SRC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              cmd_req,
    input  logic              cmd_dma_bit,
    input  logic [1:0]        mode_reg,
    input  logic [LEN_W-1:0]  len_reg,
    input  logic [SRC_W-1:0]  src_reg,
    input  logic [INC_W-1:0]  inc_reg,
    input  logic [1:0]        tgt_sel,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              dp_wr,
    input  logic [15:0]       dp_data,
    output logic [EXT_W-1:0]  ext_addr,
    input  logic [15:0]       ext_rdata,
    output logic              ww_en,
    output logic [1:0]        ww_tgt,
    output logic [ADDR_W-2:0] ww_idx,
    output logic [15:0]       ww_data,
    output logic              bw_en,
    output logic [ADDR_W-1:0] bw_addr,
    output logic [7:0]        bw_data,
    output logic [ADDR_W-1:0] br_addr,
    input  logic [7:0]        br_data,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [ADDR_W-1:0] wb_src,
    output logic              active,
    output logic              busy_stat
);
    logic                idle, run, wb;
    logic                cmd_ok, fill_ok, start;
    job_t                job_q;
    logic [SRC_HI_W-1:0] src_hi_q;
    logic [ADDR_W-1:0]   dst, src;

    assign cmd_ok  = cmd_req && dma_en && (mode_reg != MODE_FILL);
    assign fill_ok = dp_wr && cmd_dma_bit && dma_en && (mode_reg == MODE_FILL);
    assign start   = idle && (cmd_ok || fill_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q    <= '{kind: K_BUS, tgt: T_NONE, fill: 8'h00};
            src_hi_q <= '0;
        end else if (start) begin
            job_q.kind <= cmd_ok ? kind_from_mode(mode_reg) : K_FILL;
            job_q.tgt  <= tgt_e'(tgt_sel);
            job_q.fill <= dp_data[15:8];
            src_hi_q   <= src_reg[SRC_W-1:ADDR_W];
        end
    end

    vdma_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .len(len_reg),
        .idle(idle), .run(run), .wb(wb)
    );

    vdma_ptr #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_ptr (
        .clk(clk), .rst(rst), .load(start), .step(run),
        .dst_init(addr_in), .src_init(src_reg[ADDR_W-1:0]), .inc(inc_reg),
        .dst(dst), .src(src)
    );

    vdma_port #(.ADDR_W(ADDR_W), .SRC_HI_W(SRC_HI_W), .PAL_W(PAL_W)) u_port (
        .run(run), .job(job_q), .dst(dst), .src(src), .src_hi(src_hi_q),
        .ext_rdata(ext_rdata), .br_data(br_data), .ext_addr(ext_addr),
        .ww_en(ww_en), .ww_tgt(ww_tgt), .ww_idx(ww_idx), .ww_data(ww_data),
        .bw_en(bw_en), .bw_addr(bw_addr), .bw_data(bw_data), .br_addr(br_addr)
    );

    assign wb_en     = wb;
    assign wb_addr   = dst;
    assign wb_src    = src;
    assign active    = run;
    assign busy_stat = run && (job_q.kind != K_BUS);

    assert_gate_R1: assert property (@(posedge clk) disable iff (rst)
        (idle && !dma_en) |=> !active);
    assert_fill_needs_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (idle && !cmd_req && !(dp_wr && cmd_dma_bit)) |=> !active);
    assert_one_port_R4: assert property (@(posedge clk) disable iff (rst)
        !(ww_en && bw_en));
    assert_wb_follows_run_R8: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(active));
    assert_bus_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
        ww_en |-> !busy_stat);

endmodule

// File: tb/tb_vmem_dma_engine.sv
module tb_vmem_dma_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        dma_en, cmd_req, cmd_dma_bit, dp_wr;
    logic [1:0]  mode_reg, tgt_sel;
    logic [15:0] len_reg, addr_in, dp_data;
    logic [21:0] src_reg;
    logic [7:0]  inc_reg;
    logic [22:0] ext_addr;
    logic [15:0] ext_rdata;
    logic        ww_en, bw_en, wb_en, active, busy_stat;
    logic [1:0]  ww_tgt;
    logic [14:0] ww_idx;
    logic [15:0] ww_data, bw_addr, br_addr, wb_addr, wb_src;
    logic [7:0]  bw_data, br_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    function automatic int ext_word(input int a);
        return (a ^ (a >> 5) ^ 'h5a3c) & 'hffff;
    endfunction

    function automatic int vram_byte(input int a);
        return (a * 13 + 7) & 'hff;
    endfunction

    assign ext_rdata = 16'(ext_word(int'(ext_addr)));
    assign br_data   = 8'(vram_byte(int'(br_addr)));

    vmem_dma_engine dut (
        .clk(clk), .rst(rst), .dma_en(dma_en), .cmd_req(cmd_req),
        .cmd_dma_bit(cmd_dma_bit), .mode_reg(mode_reg), .len_reg(len_reg),
        .src_reg(src_reg), .inc_reg(inc_reg), .tgt_sel(tgt_sel),
        .addr_in(addr_in), .dp_wr(dp_wr), .dp_data(dp_data),
        .ext_addr(ext_addr), .ext_rdata(ext_rdata),
        .ww_en(ww_en), .ww_tgt(ww_tgt), .ww_idx(ww_idx), .ww_data(ww_data),
        .bw_en(bw_en), .bw_addr(bw_addr), .bw_data(bw_data),
        .br_addr(br_addr), .br_data(br_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_src(wb_src),
        .active(active), .busy_stat(busy_stat)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_quiet(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(tag, 128'({active, busy_stat, ww_en, bw_en, wb_en}), 128'(0));
        end
    endtask

    // kind: 0 bus, 1 fill, 2 copy
    task automatic run_op(input int kind, input int tgt, input int mode, input int addr,
                          input int inc, input int len, input int src, input int data,
                          input bit disturb, input string tag);
        int n, lo, hi;
        n  = (len == 0) ? 65536 : len;
        lo = src & 'hffff;
        hi = (src >> 16) & 'h3f;
        @(negedge clk);
        dma_en = 1'b1; mode_reg = 2'(mode); len_reg = 16'(len); src_reg = 22'(src);
        inc_reg = 8'(inc); tgt_sel = 2'(tgt); addr_in = 16'(addr);
        if (kind == 1) begin
            dp_wr = 1'b1; cmd_dma_bit = 1'b1; dp_data = 16'(data);
        end else begin
            cmd_req = 1'b1;
        end
        @(negedge clk);
        dp_wr = 1'b0; cmd_req = 1'b0;
        for (int i = 0; i < n; i++) begin
            int d, s, ea, wd, idx, bd;
            bit ew, eb;
            logic [127:0] act, exp;
            d  = (addr + i * inc) & 'hffff;
            s  = (lo + i) & 'hffff;
            ea = (hi << 17) | (s << 1);
            ew = (kind == 0) && (tgt != 3);
            eb = (kind == 2) || (kind == 1 && tgt == 0);
            wd = ext_word(ea);
            if (tgt == 0 && (d & 1) != 0) wd = ((wd & 'hff) << 8) | (wd >> 8);
            idx = (tgt == 0) ? (d >> 1) : ((d >> 1) & 63);
            bd  = (kind == 2) ? vram_byte(s) : ((data >> 8) & 'hff);
            act = {ww_en, ew ? {ww_tgt, ww_idx, ww_data} : 33'b0,
                   bw_en, eb ? {bw_addr, bw_data} : 24'b0,
                   (kind == 0) ? ext_addr : 23'b0, (kind == 2) ? br_addr : 16'b0,
                   active, busy_stat};
            exp = {ew, ew ? {2'(tgt), 15'(idx), 16'(wd)} : 33'b0,
                   eb, eb ? {16'(d), 8'(bd)} : 24'b0,
                   (kind == 0) ? 23'(ea) : 23'b0, (kind == 2) ? 16'(s) : 16'b0,
                   1'b1, (kind != 0)};
            check(tag, act, exp);
            if (disturb && i == 0) begin
                cmd_req = 1'b1; dp_wr = 1'b1; cmd_dma_bit = 1'b1; mode_reg = 2'd3;
                len_reg = 16'd9; inc_reg = 8'd7; addr_in = 16'h1234; tgt_sel = 2'd1;
                src_reg = 22'h3f0000;
            end
            @(negedge clk);
            cmd_req = 1'b0; dp_wr = 1'b0;
        end
        // write-back cycle (R8)
        check({tag, " R8 write-back"},
              128'({wb_en, wb_addr, wb_src, active, busy_stat}),
              128'({1'b1, 16'((addr + n * inc) & 'hffff), 16'((lo + n) & 'hffff), 1'b0, 1'b0}));
        @(negedge clk);
        check({tag, " R8 single pulse"}, 128'({wb_en, active}), 128'(0));
        cmd_dma_bit = 1'b0;
    endtask

    initial begin
        rst = 1'b1; dma_en = 0; cmd_req = 0; cmd_dma_bit = 0; dp_wr = 0;
        mode_reg = 0; tgt_sel = 0; len_reg = 0; addr_in = 0; dp_data = 0;
        src_reg = 0; inc_reg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset state", 128'({active, busy_stat, wb_en, ww_en, bw_en}), 128'(0));
        rst = 1'b0;

        run_op(0, 0, 0, 'h0040, 2, 5, 'h12fffe, 0, 0, "R4/R2/R7/R9 bus VRAM even");
        run_op(0, 0, 1, 'h0101, 3, 4, 'h000010, 0, 0, "R4/R3 bus VRAM odd swap");
        run_op(0, 1, 0, 'h007c, 2, 4, 'h2a0100, 0, 0, "R4 bus CRAM index wrap");
        run_op(0, 2, 1, 'hfffe, 4, 3, 'h050000, 0, 0, "R4/R7 bus VSRAM addr wrap");
        run_op(1, 0, 2, 'hfffe, 1, 4, 'h00fffe, 'habcd, 0, "R5/R7 fill VRAM");
        run_op(1, 1, 2, 'h0010, 4, 3, 'h000020, 'h55aa, 0, "R5 fill CRAM no write");
        run_op(2, 0, 3, 'h0100, 1, 5, 'h00fffd, 0, 0, "R6/R3 copy source wrap");
        run_op(0, 0, 0, 'h0200, 2, 3, 'h000400, 0, 1, "R1 retrigger ignored");

        // R1: enable low ignores both triggers
        @(negedge clk);
        dma_en = 0; mode_reg = 0; len_reg = 3; cmd_req = 1;
        @(negedge clk);
        cmd_req = 0; mode_reg = 2; dp_wr = 1; cmd_dma_bit = 1;
        @(negedge clk);
        dp_wr = 0; cmd_dma_bit = 0;
        expect_quiet(3, "R1 disabled ignored");

        // R3: command with fill mode starts nothing
        dma_en = 1; mode_reg = 2; cmd_req = 1;
        @(negedge clk);
        cmd_req = 0;
        expect_quiet(3, "R3 fill mode command ignored");

        // R5: data write without transfer bit starts nothing
        dp_wr = 1; cmd_dma_bit = 0; dp_data = 16'hffff;
        @(negedge clk);
        dp_wr = 0;
        expect_quiet(3, "R5 fill needs transfer bit");

        // R2: zero length means 65536 units
        run_op(0, 3, 0, 'h0300, 5, 0, 'h01abcd, 0, 0, "R2 zero length");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule